// File: doc/BRIEF.md
# Reloadable Table-Based Constant Multiplier

This block multiplies a small unsigned operand by a constant with no arithmetic multiplier in the datapath. Every product bit has its own small writable table of 2^IN_W one-bit cells. All the tables take the operand as their address, and a register captures the bits they read out. The product therefore appears one clock after the operand is applied.

When a new constant is requested, a filler controller walks the operand addresses from zero upward, one per clock. It builds each product with a running sum that grows by the constant at every step and writes the bits of that sum into the tables. Only the stored bits change. The address and output wiring of the tables stay fixed. While the fill runs, the block reports busy and marks its product as invalid. A one-cycle done pulse marks the end of the fill.

Top module: `table_cmul`

## Requirements
- R1: After reset, busy and done are 0, prod_valid is 1, and the loaded constant is zero, so the product is 0 for every operand.
- R2: While idle, prod_out equals (K * x) mod 2^OUT_W one clock after operand x is applied on mul_in, with prod_valid at 1. K is the constant of the last completed fill.
- R3: A load_req seen while idle starts a fill: busy is 1 from the next cycle and stays 1 for exactly 2^IN_W cycles.
- R4: done is 1 for exactly one cycle, the first cycle after busy falls, and busy is 0 in that cycle.
- R5: prod_valid is 0 in every cycle that follows a cycle in which busy was 1.
- R6: A load_req that arrives during a fill is ignored. The fill keeps its length and its constant, and no second fill follows it.
- R7: When K * x does not fit in OUT_W bits, the stored product keeps only its low OUT_W bits. For example, with IN_W=3 and OUT_W=6, K=15 and x=7 give 41.
- R8: A load_req in the cycle where done is 1 is accepted, and busy is 1 again in the next cycle.
- R9: Loading K=0 makes every product 0, and loading K=1 makes the product equal to the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_in | input | IN_W | Operand used as the table address |
| prod_out | output | OUT_W | Registered product |
| prod_valid | output | 1 | Product reflects a complete table |
| load_req | input | 1 | Request to load load_const |
| load_const | input | K_W | New constant |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse after the last entry is written |

## Verification
The bench builds the block with IN_W=3, K_W=4 and OUT_W=6. A full fill then takes only eight cycles, so every operand can be swept after each load. Because a 4-bit constant times the largest 3-bit operand reaches 105, the truncation path is exercised by ordinary loads. The directed loads use constants 0, 1, 2, 3, 5 and 15. Randomly drawn constants follow, along with a load request made in the middle of a fill and a new load requested in the same cycle as done.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cmul_bit_table.sv
// One output bit: a bank of 2**AW writable cells, read combinationally.
module cmul_bit_table #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] cells_q;
  logic [DEPTH-1:0] cells_d;

  always_comb begin
    cells_d = cells_q;
    if (wr_en) cells_d[wr_addr] = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells_q <= '0;
    else if (wr_en) cells_q <= cells_d;
  end

  assign rd_bit = cells_q[rd_addr];
endmodule

// File: rtl/cmul_filler.sv
// Walks all addresses in ascending order, producing K*addr by accumulation.
module cmul_filler
  import cmul_pkg::*;
#(
  parameter int IN_W  = 3,
  parameter int K_W   = 4,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [K_W-1:0]   load_const,
  output logic             wr_en,
  output logic [IN_W-1:0]  wr_addr,
  output logic [OUT_W-1:0] wr_data,
  output logic             busy,
  output logic             done
);
  localparam logic [IN_W-1:0] LAST_ADDR = {IN_W{1'b1}};

  fill_state_e      state_q, state_d;
  logic [IN_W-1:0]  addr_q, addr_d;
  logic [OUT_W-1:0] acc_q, acc_d;
  logic [OUT_W-1:0] step_q, step_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    acc_d   = acc_q;
    step_d  = step_q;
    done_d  = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (load_req) begin
          state_d = FS_FILL;
          step_d  = OUT_W'(load_const);
          addr_d  = '0;
          acc_d   = '0;
        end
      end
      FS_FILL: begin
        addr_d = addr_q + IN_W'(1);
        acc_d  = acc_q + step_q;
        if (addr_q == LAST_ADDR) begin
          state_d = FS_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      acc_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      acc_q   <= acc_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign wr_en   = (state_q == FS_FILL);
  assign wr_addr = addr_q;
  assign wr_data = acc_q;
  assign busy    = (state_q == FS_FILL);
  assign done    = done_q;
endmodule

// File: rtl/table_cmul.sv
module table_cmul #(
  parameter int IN_W  = 3,
  parameter int K_W   = 4,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  mul_in,
  output logic [OUT_W-1:0] prod_out,
  output logic             prod_valid,
  input  logic             load_req,
  input  logic [K_W-1:0]   load_const,
  output logic             busy,
  output logic             done
);
  logic             fill_we;
  logic [IN_W-1:0]  fill_addr;
  logic [OUT_W-1:0] fill_data;
  logic [OUT_W-1:0] lut_bits;
  logic [OUT_W-1:0] prod_q;
  logic             valid_q;

  cmul_filler #(.IN_W(IN_W), .K_W(K_W), .OUT_W(OUT_W)) u_filler (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .load_const (load_const),
    .wr_en      (fill_we),
    .wr_addr    (fill_addr),
    .wr_data    (fill_data),
    .busy       (busy),
    .done       (done)
  );

  for (genvar b = 0; b < OUT_W; b++) begin : g_bit
    cmul_bit_table #(.AW(IN_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fill_we),
      .wr_addr (fill_addr),
      .wr_bit  (fill_data[b]),
      .rd_addr (mul_in),
      .rd_bit  (lut_bits[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      valid_q <= 1'b1;
    end else begin
      prod_q  <= lut_bits;
      valid_q <= ~busy;
    end
  end

  assign prod_out   = prod_q;
  assign prod_valid = valid_q;
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
  parameter int IN_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic load_req,
  input logic prod_valid,
  input logic busy,
  input logic done
);
  localparam int FILL_N = 1 << IN_W;

  logic [IN_W:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  a_r3_start_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_req));
  a_r3_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(busy_cnt) == FILL_N));
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(busy_cnt) < FILL_N));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_invalid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !prod_valid);
endmodule

bind table_cmul cmul_checker #(.IN_W(IN_W)) u_cmul_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_req   (load_req),
  .prod_valid (prod_valid),
  .busy       (busy),
  .done       (done)
);

// File: tb/table_cmul_bench.sv
module table_cmul_bench;
  localparam int IN_W  = 3;
  localparam int K_W   = 4;
  localparam int OUT_W = 6;
  localparam int N     = 1 << IN_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IN_W-1:0]  mul_in = '0;
  logic [OUT_W-1:0] prod_out;
  logic             prod_valid;
  logic             load_req = 1'b0;
  logic [K_W-1:0]   load_const = '0;
  logic             busy;
  logic             done;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  table_cmul #(.IN_W(IN_W), .K_W(K_W), .OUT_W(OUT_W)) u_table_cmul (
    .clk(clk), .rst_n(rst_n), .mul_in(mul_in), .prod_out(prod_out),
    .prod_valid(prod_valid), .load_req(load_req), .load_const(load_const),
    .busy(busy), .done(done)
  );

  function automatic int exp_prod(input int k, input int x);
    return (k * x) % (1 << OUT_W);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Exhaustive operand sweep against constant k
  task automatic sweep(input string req, input int k);
    for (int x = 0; x < N; x++) begin
      mul_in = IN_W'(x);
      @(negedge clk);
      chk(req, int'(prod_out), exp_prod(k, x));
      chk(req, int'(prod_valid), 1);
    end
  endtask

  // Wait out a fill that is already running; optionally poke load_req mid-fill
  task automatic finish_fill(input bit poke, input int poke_k);
    int cnt = 1;
    @(negedge clk);
    while (busy && cnt < 4 * N) begin
      if (cnt == 2) chk("R5", int'(prod_valid), 0);
      if (poke && cnt == 3) begin
        load_req = 1'b1;
        load_const = K_W'(poke_k);
      end else begin
        load_req = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    load_req = 1'b0;
    chk(poke ? "R6" : "R3", cnt, N);
    chk("R4", int'(done), 1);
    chk("R4", int'(busy), 0);
  endtask

  task automatic do_load(input int k, input bit poke, input int poke_k);
    load_req = 1'b1;
    load_const = K_W'(k);
    @(negedge clk);
    load_req = 1'b0;
    chk("R3", int'(busy), 1);
    finish_fill(poke, poke_k);
    @(negedge clk);
    chk("R4", int'(done), 0);
    chk(poke ? "R6" : "R3", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    int x;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(busy), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(prod_valid), 1);
    sweep("R1", 0);

    // R2: directed constants
    do_load(3, 1'b0, 0);  sweep("R2", 3);
    do_load(5, 1'b0, 0);  sweep("R2", 5);
    do_load(2, 1'b0, 0);  sweep("R2", 2);
    // R7: truncation
    do_load(15, 1'b0, 0); sweep("R7", 15);
    mul_in = 3'd7;
    @(negedge clk);
    chk("R7", int'(prod_out), 41);
    // R9: zero and identity
    do_load(0, 1'b0, 0);  sweep("R9", 0);
    do_load(1, 1'b0, 0);  sweep("R9", 1);

    // R6: request during fill ignored
    do_load(7, 1'b1, 12);
    sweep("R6", 7);

    // R8: request accepted in the done cycle
    load_req = 1'b1;
    load_const = 4'd9;
    @(negedge clk);
    load_req = 1'b0;
    finish_fill(1'b0, 0);
    load_req = 1'b1;
    load_const = 4'd11;
    @(negedge clk);
    load_req = 1'b0;
    chk("R8", int'(busy), 1);
    finish_fill(1'b0, 0);
    @(negedge clk);
    sweep("R8", 11);

    // Random constants and operands
    for (int i = 0; i < 14; i++) begin
      k = int'($urandom % 16);
      do_load(k, 1'b0, 0);
      sweep("R2", k);
      for (int j = 0; j < 10; j++) begin
        x = int'($urandom % N);
        mul_in = IN_W'(x);
        @(negedge clk);
        chk("R2", int'(prod_out), exp_prod(k, x));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule